// File: doc/BRIEF.md
# Serial Register Access Target

This block is the device end of a narrow serial control port. It watches one command line, sampled once per serial clock cycle, for a fixed 32-cycle frame. Each frame carries a two-bit operation, an identifier byte and a register address. It then either writes one byte into a small bank of 8-bit configuration registers or shifts one register out on the serial output. Several targets can share the command line while their serial input and output pins are chained. A target that is not chosen for a read forwards its serial input to its serial output, so that read data from a device further down the chain reaches the controller.

Frame layout, in order of arrival: start pattern `1100`, op (2 bits), identifier byte (`00` then the 6-bit ID), address (8 bits), a zero gap bit, 8 data bits, a final zero bit. The ID register sits at register address 0, resets to zero, and can be written like any other register. The other registers keep their contents through reset.

The frame FSM has five named states. HUNT looks for the start pattern and goes to HEADER when it is seen. HEADER collects 18 bits and then goes to GAP. GAP always goes to DATA. DATA collects 8 bits and then goes to TAIL. TAIL always returns to HUNT. A new frame may begin in the cycle right after TAIL.

Top module: `sreg_target`

## Requirements
- R1: The start pattern `1100` is recognised in HUNT on four consecutive command-line bits, and each frame takes exactly 32 cycles. A second frame may follow with no idle cycles between.
- R2: After the start pattern come the op bits, the identifier byte, the address, one gap bit, 8 data bits (MSB first) and one final bit, in that order.
- R3: Op `00` writes only when the identifier byte equals `00` followed by the ID register's low 6 bits. A write with any other identifier byte leaves the registers unchanged.
- R4: Op `01` writes the register whatever the identifier byte holds.
- R5: On op `10` with a matching identifier byte, the serial output carries the addressed register, MSB first, in the same 8 cycles as frame bits 23 to 30.
- R6: On op `11`, the device drives the addressed register in that window whatever the identifier byte holds.
- R7: On op `10` with a non-matching identifier byte, the serial output equals the serial input in the same cycle throughout the data window.
- R8: The serial output is 0 outside the data window, and during the whole of any write frame whatever the serial input does.
- R9: A write takes effect only when the final bit is 0. A frame cut short by reset leaves the registers unchanged, and reset does not clear registers other than the ID register.
- R10: The ID register is register address 0 and resets to 0. Only its low 6 bits form the device ID.
- R11: Addresses at or above the bank depth (8 by default) are ignored by writes and read back as 0. The last in-range address, 7, works normally.
- R12: Command-line activity that does not contain `1100` leaves the target in HUNT, causes no write, and does not stop the next real frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; the command line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to HUNT |
| cmd_in | input | 1 | Command line carrying the framed transaction |
| ser_in | input | 1 | Serial input from the previous device in the chain |
| ser_out | output | 1 | Serial output: read data, forwarded input, or 0 |

## Verification
The register file is written with distinct byte patterns through device, broadcast, mismatched and out-of-range writes, and each is read back. This tells apart a write that landed from one that was correctly dropped. Reads are tried matched, mismatched and forced, with a recognisable pattern on the serial input, so that driven data, forwarded data and a silent output each give a different byte. Writes with the serial input toggling show that the output stays quiet. A write with a 1 in the final bit, a write cut by reset, and a burst of non-start noise confirm that none of them alters stored data, and that the reset moves the ID back to 0.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam logic [3:0] START_PAT = 4'b1100;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HEADER,
        ST_GAP,
        ST_DATA,
        ST_TAIL
    } frame_state_t;

    typedef enum logic [1:0] {
        OP_DEV_WR = 2'b00,
        OP_ALL_WR = 2'b01,
        OP_DEV_RD = 2'b10,
        OP_ALL_RD = 2'b11
    } op_t;

    typedef enum logic [1:0] {
        OUT_QUIET,
        OUT_DRIVE,
        OUT_PASS
    } out_mode_t;
endpackage

// File: rtl/sreg_frame_fsm.sv
module sreg_frame_fsm
    import sreg_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_in,
    output frame_state_t         state_o,
    output op_t                  op_o,
    output logic [7:0]           idbyte_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [DATA_W-1:0]    data_o,
    output logic                 commit_o
);
    localparam int IDB_W = 8;
    localparam int HDR_W = 2 + IDB_W + ADDR_W;
    localparam int CNT_W = $clog2(HDR_W);

    frame_state_t        state, state_nx;
    logic [2:0]          hist;
    logic [HDR_W-1:0]    hdr;
    logic [DATA_W-1:0]   dat;
    logic [CNT_W-1:0]    cnt;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:   if ({hist, cmd_in} == START_PAT) state_nx = ST_HEADER;
            ST_HEADER: if (cnt == CNT_W'(HDR_W - 1)) state_nx = ST_GAP;
            ST_GAP:    state_nx = ST_DATA;
            ST_DATA:   if (cnt == CNT_W'(DATA_W - 1)) state_nx = ST_TAIL;
            ST_TAIL:   state_nx = ST_HUNT;
            default:   state_nx = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // Field capture and bit counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            hdr  <= '0;
            dat  <= '0;
            cnt  <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    hist <= {hist[1:0], cmd_in};
                    cnt  <= '0;
                end
                ST_HEADER: begin
                    hist <= '0;
                    hdr  <= {hdr[HDR_W-2:0], cmd_in};
                    cnt  <= (cnt == CNT_W'(HDR_W - 1)) ? '0 : cnt + 1'b1;
                end
                ST_GAP: begin
                    hist <= '0;
                    cnt  <= '0;
                end
                ST_DATA: begin
                    hist <= '0;
                    dat  <= {dat[DATA_W-2:0], cmd_in};
                    cnt  <= cnt + 1'b1;
                end
                ST_TAIL: begin
                    hist <= '0;
                    cnt  <= '0;
                end
                default: begin
                    hist <= '0;
                    cnt  <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        state_o  = state;
        op_o     = op_t'(hdr[HDR_W-1 -: 2]);
        idbyte_o = hdr[ADDR_W +: IDB_W];
        addr_o   = hdr[ADDR_W-1:0];
        data_o   = dat;
        commit_o = (state == ST_TAIL) && !cmd_in;
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int ID_W     = 6,
    parameter int NUM_REGS = 8,
    parameter int ID_ADDR  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [ID_W-1:0]   dev_id
);
    logic [NUM_REGS*DATA_W-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = we && (waddr == ADDR_W'(g));
        if (g == ID_ADDR) begin : g_id
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wdata;
            end
        end else begin : g_cfg
            always_ff @(posedge clk) begin
                if (hit) q <= wdata;
            end
        end
        assign flat[g*DATA_W +: DATA_W] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == ADDR_W'(i)) rdata = flat[i*DATA_W +: DATA_W];
        end
    end

    assign dev_id = flat[ID_ADDR*DATA_W +: ID_W];
endmodule

// File: rtl/sreg_out_unit.sv
module sreg_out_unit
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_state_t      state_i,
    input  op_t               op_i,
    input  logic              match_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              ser_in,
    output logic              ser_out,
    output out_mode_t         mode_o
);
    out_mode_t         mode, mode_pick;
    logic [DATA_W-1:0] shreg;

    always_comb begin
        unique case (op_i)
            OP_DEV_RD: mode_pick = match_i ? OUT_DRIVE : OUT_PASS;
            OP_ALL_RD: mode_pick = OUT_DRIVE;
            default:   mode_pick = OUT_QUIET;
        endcase
    end

    // The gap cycle loads the register and picks the output mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= OUT_QUIET;
            shreg <= '0;
        end else begin
            unique case (state_i)
                ST_GAP: begin
                    mode  <= mode_pick;
                    shreg <= rdata_i;
                end
                ST_DATA: shreg <= {shreg[DATA_W-2:0], 1'b0};
                default: mode  <= OUT_QUIET;
            endcase
        end
    end

    always_comb begin
        ser_out = 1'b0;
        if (state_i == ST_DATA) begin
            unique case (mode)
                OUT_DRIVE: ser_out = shreg[DATA_W-1];
                OUT_PASS:  ser_out = ser_in;
                default:   ser_out = 1'b0;
            endcase
        end
        mode_o = mode;
    end
endmodule

// File: rtl/sreg_target.sv
module sreg_target
    import sreg_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    parameter int ID_ADDR  = 0
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cmd_in,
    input  logic ser_in,
    output logic ser_out
);
    localparam int PAD_W = 8 - ID_W;

    frame_state_t       fsm_state;
    op_t                frame_op;
    logic [7:0]         frame_idb;
    logic [ADDR_W-1:0]  frame_addr;
    logic [DATA_W-1:0]  frame_data;
    logic               frame_commit;
    logic [DATA_W-1:0]  bank_rdata;
    logic [ID_W-1:0]    dev_id;
    logic               id_match;
    logic               bank_we;
    out_mode_t          out_mode;

    sreg_frame_fsm #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(sclk), .rst_n(rst_n), .cmd_in(cmd_in),
        .state_o(fsm_state), .op_o(frame_op), .idbyte_o(frame_idb),
        .addr_o(frame_addr), .data_o(frame_data), .commit_o(frame_commit)
    );

    assign id_match = (frame_idb == {{PAD_W{1'b0}}, dev_id});
    assign bank_we  = frame_commit &&
                      (((frame_op == OP_DEV_WR) && id_match) || (frame_op == OP_ALL_WR));

    sreg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W),
                .NUM_REGS(NUM_REGS), .ID_ADDR(ID_ADDR)) u_bank (
        .clk(sclk), .rst_n(rst_n), .we(bank_we), .waddr(frame_addr),
        .wdata(frame_data), .raddr(frame_addr), .rdata(bank_rdata), .dev_id(dev_id)
    );

    sreg_out_unit #(.DATA_W(DATA_W)) u_out (
        .clk(sclk), .rst_n(rst_n), .state_i(fsm_state), .op_i(frame_op),
        .match_i(id_match), .rdata_i(bank_rdata), .ser_in(ser_in),
        .ser_out(ser_out), .mode_o(out_mode)
    );
endmodule

// File: rtl/sreg_target_chk.sv
module sreg_target_chk
    import sreg_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input frame_state_t st,
    input out_mode_t    mode,
    input op_t          op,
    input logic         we,
    input logic         cmd_in,
    input logic         sdi,
    input logic         sdo
);
    AST_TAIL_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_TAIL |=> st == ST_HUNT); // R1
    AST_GAP_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_GAP |=> st == ST_DATA); // R2
    AST_WRITE_NEEDS_WRITE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !op[1]); // R3
    AST_PASS_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && mode == OUT_PASS) |-> sdo == sdi); // R7
    AST_QUIET_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_DATA |-> !sdo); // R8
    AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && !op[1]) |-> !sdo); // R8
    AST_WRITE_ONLY_AT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (st == ST_TAIL && !cmd_in)); // R9
endmodule

bind sreg_target sreg_target_chk u_chk (
    .clk(sclk), .rst_n(rst_n), .st(fsm_state), .mode(out_mode), .op(frame_op),
    .we(bank_we), .cmd_in(cmd_in), .sdi(ser_in), .sdo(ser_out)
);

// File: tb/sim_sreg_target.sv
`timescale 1ns/1ps
module sim_sreg_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_in = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;

    int n_checks = 0;
    int n_fail = 0;
    int bitpos = -1;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    sreg_target u0 (.sclk(clk), .rst_n(rst_n), .cmd_in(cmd_in),
                    .ser_in(ser_in), .ser_out(ser_out));

    task automatic check(input logic ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_in = 1'b0; ser_in = 1'b0; bitpos = -1;
        end
    endtask

    // Driver: pushes the expected data-window byte, then drives 32 frame bits.
    // cut >= 0 applies reset in place of frame bit number cut.
    task automatic send(input logic [1:0] op, input logic [5:0] id,
                        input logic [7:0] addr, input logic [7:0] wd,
                        input logic [7:0] sdi_b, input logic fin,
                        input logic [7:0] exp, input string tag, input int cut);
        logic [31:0] fr;
        item_t it;
        fr = {4'b1100, op, 2'b00, id, addr, 1'b0, wd, fin};
        if (cut < 0) begin
            it.exp = exp; it.tag = tag; sbq.push_back(it);
        end
        for (int k = 0; k < 32; k++) begin
            if (cut >= 0 && k == cut) begin
                @(negedge clk);
                rst_n = 1'b0; cmd_in = 1'b0; ser_in = 1'b0; bitpos = -1;
                repeat (2) @(negedge clk);
                rst_n = 1'b1;
                return;
            end
            @(negedge clk);
            cmd_in = fr[31-k];
            ser_in = (k >= 23 && k <= 30) ? sdi_b[3'(30-k)] : 1'b0;
            bitpos = k;
        end
    endtask

    // Monitor: collects the data window just before each sampling edge
    initial begin
        logic [7:0] acc;
        item_t it;
        acc = '0;
        forever begin
            @(negedge clk);
            #1;
            if (bitpos >= 23 && bitpos <= 30) begin
                acc = {acc[6:0], ser_out};
                if (bitpos == 30) begin
                    if (sbq.size() == 0) begin
                        check(1'b0, "scoreboard empty", acc, 8'h00);
                    end else begin
                        it = sbq.pop_front();
                        check(acc == it.exp, it.tag, acc, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual 00 expected 01");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        #1;
        check(ser_out == 1'b0, "R8 idle output after reset", {7'b0, ser_out}, 8'h00);

        // ID register reads 0 after reset; forced read ignores identifier
        send(2'b11, 6'd9, 8'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R10 R6 id reset value", -1);
        // Set ID to 5 (current ID 0 matches); sdi toggles but output stays quiet
        send(2'b00, 6'd0, 8'd0, 8'h05, 8'hFF, 1'b0, 8'h00, "R8 R10 quiet on id write", -1);
        send(2'b10, 6'd5, 8'd0, 8'h00, 8'h00, 1'b0, 8'h05, "R5 R10 id readback", -1);
        // Device write and read, back to back frames
        send(2'b00, 6'd5, 8'd3, 8'hA5, 8'h5A, 1'b0, 8'h00, "R8 R3 quiet on write", -1);
        send(2'b10, 6'd5, 8'd3, 8'h00, 8'h00, 1'b0, 8'hA5, "R1 R2 R3 R5 write then read", -1);
        // Mismatched device write is dropped
        send(2'b00, 6'd7, 8'd3, 8'h11, 8'h00, 1'b0, 8'h00, "R3 mismatched write frame", -1);
        send(2'b10, 6'd5, 8'd3, 8'h00, 8'h00, 1'b0, 8'hA5, "R3 mismatched write ignored", -1);
        // Broadcast write
        send(2'b01, 6'd9, 8'd4, 8'h3C, 8'h00, 1'b0, 8'h00, "R4 broadcast frame", -1);
        send(2'b10, 6'd5, 8'd4, 8'h00, 8'h00, 1'b0, 8'h3C, "R4 broadcast readback", -1);
        // Mismatched read forwards serial input
        send(2'b10, 6'd9, 8'd3, 8'h00, 8'h96, 1'b0, 8'h96, "R7 pass-through", -1);
        // Forced read
        send(2'b11, 6'd9, 8'd3, 8'h00, 8'h96, 1'b0, 8'hA5, "R6 forced read", -1);
        // Final bit 1 cancels the write
        send(2'b00, 6'd5, 8'd3, 8'h77, 8'h00, 1'b1, 8'h00, "R9 bad final bit frame", -1);
        send(2'b10, 6'd5, 8'd3, 8'h00, 8'h00, 1'b0, 8'hA5, "R9 bad final bit ignored", -1);
        idle(3);
        // Noise without the start pattern
        begin
            logic [9:0] noise;
            noise = 10'b1011010000;
            for (int i = 9; i >= 0; i--) begin
                @(negedge clk);
                cmd_in = noise[i]; ser_in = 1'b0; bitpos = -1;
            end
        end
        send(2'b10, 6'd5, 8'd4, 8'h00, 8'h00, 1'b0, 8'h3C, "R12 frame after noise", -1);
        // Address range
        send(2'b00, 6'd5, 8'd200, 8'hEE, 8'h00, 1'b0, 8'h00, "R11 out of range write", -1);
        send(2'b10, 6'd5, 8'd200, 8'h00, 8'h00, 1'b0, 8'h00, "R11 out of range read", -1);
        send(2'b01, 6'd0, 8'd7, 8'h81, 8'h00, 1'b0, 8'h00, "R11 last address write", -1);
        send(2'b10, 6'd5, 8'd7, 8'h00, 8'h00, 1'b0, 8'h81, "R11 last address read", -1);
        // Reset in the data window of a write
        send(2'b00, 6'd5, 8'd3, 8'h77, 8'h00, 1'b0, 8'h00, "R9 cut frame", 28);
        idle(2);
        send(2'b10, 6'd0, 8'd3, 8'h00, 8'h00, 1'b0, 8'hA5, "R9 R10 cut write left data", -1);
        send(2'b10, 6'd5, 8'd3, 8'h00, 8'h3F, 1'b0, 8'h3F, "R10 R7 old id no longer matches", -1);
        idle(4);
        check(sbq.size() == 0, "R1 all frames completed", 8'(sbq.size()), 8'h00);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule